// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Buffer and Shift Flags

This block is the sending half of an asynchronous serial channel that software drives through byte-wide registers. A character written into the one-entry holding buffer moves into a shift register on a bit-rate tick. The block then drives a frame onto the line. The frame is a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit lasts exactly one tick interval. The tick comes from an external bit-rate generator as a one-cycle enable.

An 8-bit control input sets the frame shape. It carries the channel clock enable, the transmit enable, the parity mode, the character length and the stop-bit count. A 2-bit status output shows a character waiting in the buffer and a frame in progress as two separate flags. A one-cycle completion pulse marks the end of each frame. When the channel is switched on after being off, a start-up guard holds back the first frame until two bit ticks have gone by. Clearing the clock enable returns the line to idle at once and drops everything pending.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the line output is 1, both status flags are 0 and the completion pulse is 0.
- R2: Control bit 7 is the clock enable and bit 6 is the transmit enable. A buffer write is accepted only while both are 1; otherwise it has no effect. Control bit 5 (receive enable) has no effect on the transmitter.
- R3: A write made while status bit 1 (buffer full) is set is ignored, and the buffered character is kept.
- R4: A frame starts with a 0 start bit and is followed by the data bits, least significant first. Control bit 2 set sends 8 data bits; clear sends the low 7 bits. Each bit holds the line for one tick interval, and every change of the line occurs on a tick.
- R5: Control bits 4:3 select the parity bit that follows the data. 00 sends no bit, 01 always sends 0, 10 sends odd parity over the sent data bits, and 11 sends even parity.
- R6: Control bit 1 set sends two 1 stop bits; clear sends one.
- R7: Status bit 1 is set while a character waits in the buffer, and status bit 0 is set while a frame is being sent. With the shifter idle and the buffer full, the next tick moves the character to the shifter, clearing bit 1 and setting bit 0 in the same cycle the start bit appears.
- R8: The tick that ends the last stop bit raises the completion output for exactly one cycle. In that cycle the line is 1 and status bit 0 is 0.
- R9: After clock enable and transmit enable become both set, the first frame starts no earlier than the third tick. The first two ticks are counted as the guard.
- R10: Clearing the clock enable forces the line to 1 and both status flags to 0 in the same cycle, aborts the frame, and discards the buffered character.
- R11: Length, parity and stop settings are captured when a frame starts. Changing them during the frame has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 8 | Control byte: [7] clock enable, [6] transmit enable, [5] receive enable (unused), [4:3] parity, [2] 8-bit, [1] two stops |
| tick_i | input | 1 | One-cycle bit-rate enable |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 8 | Character to buffer |
| txd_o | output | 1 | Serial line, idle high |
| stat_o | output | 2 | [1] buffer full, [0] shifting |
| tx_done_o | output | 1 | One-cycle frame-complete pulse |

## Verification
The bench sweeps every combination of parity mode, length and stop count over data patterns that include all-zeros, all-ones and alternating bits. This catches a wrong parity sense or a parity bit that leaks into 7-bit frames as a flipped or missing bit in the captured frame. Back-to-back writes test the full-buffer case: a design that overwrote the buffer would send the second byte. Queued writes show both flags at once. The start-up guard is timed to the exact tick: an off-by-one guard starts the frame on the second or fourth tick. Dropping the clock enable mid-frame with a byte queued would leave the line low or replay the byte if handled wrongly. A control change mid-frame would corrupt the frame if settings were not captured at load.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  typedef enum logic [1:0] {
    PAR_NONE = 2'b00,
    PAR_ZERO = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_EVEN = 2'b11
  } par_mode_e;

  typedef struct packed {
    logic      clk_en;
    logic      tx_en;
    logic      rx_en;
    par_mode_e par;
    logic      len8;
    logic      stop2;
    logic      spare;
  } ctrl_t;

endpackage

// File: rtl/tx_hold_buf.sv
module tx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              take_i,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_o <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      full_o <= 1'b0;
    end else if (take_i) begin
      full_o <= 1'b0;
    end else if (wr_i && !full_o) begin
      full_o <= 1'b1;
      data_o <= data_i;
    end
  end

endmodule

// File: rtl/tx_start_guard.sv
module tx_start_guard #(
  parameter int GUARD_TICKS = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  output logic ready_o
);

  localparam int GW = $clog2(GUARD_TICKS + 1);
  localparam logic [GW-1:0] GLIM = GW'(GUARD_TICKS);

  logic [GW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (!en_i)                   cnt_q <= '0;
    else if (tick_i && cnt_q != GLIM) cnt_q <= cnt_q + 1'b1;
  end

  assign ready_o = en_i && (cnt_q == GLIM);

endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  par_mode_e         par_i,
  input  logic              len8_i,
  input  logic              stop2_i,
  output logic              busy_o,
  output logic              bit_o,
  output logic              done_o
);

  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame, sh_q;
  logic [CNT_W-1:0]   len, cnt_q;
  logic [DATA_W-1:0]  dm;
  logic               has_par, pbit;

  always_comb begin
    dm = data_i;
    if (!len8_i) dm[DATA_W-1] = 1'b0;
    has_par = (par_i != PAR_NONE);
    unique case (par_i)
      PAR_ODD:  pbit = ~(^dm);
      PAR_EVEN: pbit = ^dm;
      default:  pbit = 1'b0;
    endcase
    frame = '1;
    frame[0] = 1'b0;
    frame[DATA_W-1:1] = data_i[DATA_W-2:0];
    if (len8_i) begin
      frame[DATA_W] = data_i[DATA_W-1];
      if (has_par) frame[DATA_W+1] = pbit;
    end else if (has_par) begin
      frame[DATA_W] = pbit;
    end
    len = CNT_W'(DATA_W + 1) + CNT_W'(len8_i) + CNT_W'(has_par) + CNT_W'(stop2_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else if (clr_i) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (tick_i && busy_o) begin
        if (cnt_q == CNT_W'(1)) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
          sh_q   <= '1;
        end else begin
          sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
          cnt_q <= cnt_q - 1'b1;
        end
      end else if (load_i) begin
        sh_q   <= frame;
        cnt_q  <= len;
        busy_o <= 1'b1;
      end
    end
  end

  assign bit_o = sh_q[0];

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int GUARD_TICKS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [7:0]        ctrl_i,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              txd_o,
  output logic [1:0]        stat_o,
  output logic              tx_done_o
);

  ctrl_t             c;
  logic              clr, run, wr_ok, take, full, ready, busy, sbit, done;
  logic [DATA_W-1:0] bdata;
  logic              unused_ctrl;

  assign c           = ctrl_t'(ctrl_i);
  assign unused_ctrl = ^{c.rx_en, c.spare};
  assign clr         = ~c.clk_en;
  assign run         = c.clk_en & c.tx_en;
  assign wr_ok       = wr_en_i & run;
  assign take        = tick_i & ~busy & full & ready;

  tx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk_i, .rst_ni, .clr_i(clr), .wr_i(wr_ok), .data_i(wr_data_i),
    .take_i(take), .full_o(full), .data_o(bdata)
  );

  tx_start_guard #(.GUARD_TICKS(GUARD_TICKS)) u_guard (
    .clk_i, .rst_ni, .en_i(run), .tick_i, .ready_o(ready)
  );

  tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i, .load_i(take), .data_i(bdata),
    .par_i(c.par), .len8_i(c.len8), .stop2_i(c.stop2),
    .busy_o(busy), .bit_o(sbit), .done_o(done)
  );

  // clock-enable low gates outputs in the same cycle
  assign txd_o     = clr | sbit;
  assign stat_o    = {full & c.clk_en, busy & c.clk_en};
  assign tx_done_o = done & c.clk_en;

endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [7:0] ctrl_i,
  input logic       tick_i,
  input logic       wr_en_i,
  input logic       txd_o,
  input logic [1:0] stat_o,
  input logic       tx_done_o
);

  a_r3_full_needs_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[1]) |-> $past(wr_en_i));

  a_r7_load_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(stat_o[0]) |-> ($past(tick_i) && !stat_o[1] && !txd_o));

  a_r4_line_moves_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i[7] && $past(ctrl_i[7]) && !$past(tick_i)) |-> $stable(txd_o));

  a_r8_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> (txd_o && !stat_o[0]));

  a_r8_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);

  a_r10_disable_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i[7] |=> (stat_o == 2'b00 && txd_o && !tx_done_o));

endmodule

bind uart_tx_core uart_tx_chk u_chk (.*);

// File: tb/sim_uart_tx_core.sv
`timescale 1ns/1ps
module sim_uart_tx_core;

  localparam int DIV = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] ctrl_r = 8'h00;
  logic       txd, done;
  logic [1:0] stat;
  int         tcnt = 0;
  int         nchk = 0;
  int         nerr = 0;

  uart_tx_core u0 (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl_r), .tick_i(tick),
    .wr_en_i(wr), .wr_data_i(wdata), .txd_o(txd), .stat_o(stat), .tx_done_o(done)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    tick <= (tcnt == DIV - 1);
    tcnt <= (tcnt == DIV - 1) ? 0 : tcnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic void build(input logic [7:0] c, input logic [7:0] d,
                                output logic [11:0] f, output int n);
    int idx, len, ones;
    f = '1; idx = 0; ones = 0;
    f[idx] = 1'b0; idx++;
    len = c[2] ? 8 : 7;
    for (int i = 0; i < len; i++) begin
      f[idx] = d[i]; idx++;
      ones += int'(d[i]);
    end
    case (c[4:3])
      2'b01: begin f[idx] = 1'b0; idx++; end
      2'b10: begin f[idx] = ((ones % 2) == 0); idx++; end
      2'b11: begin f[idx] = ((ones % 2) == 1); idx++; end
      default: ;
    endcase
    idx += c[1] ? 2 : 1;
    n = idx;
  endfunction

  task automatic wait_tick_post();
    do @(posedge clk); while (!tick);
    #1;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic wait_start(output bit seen);
    seen = 0;
    for (int k = 0; k < 40 && !seen; k++) begin
      wait_tick_post();
      if (txd == 1'b0) seen = 1;
    end
  endtask

  task automatic capture(input logic [7:0] c_exp, input logic [7:0] d, input bit chg,
                         input logic [7:0] c_new, input string tag);
    logic [11:0] f, got;
    int n;
    bit seen;
    build(c_exp, d, f, n);
    wait_start(seen);
    chk(seen, {tag, " R4 start bit seen"}, 32'(seen), 1);
    chk(stat == 2'b01, {tag, " R7 flags at load"}, 32'(stat), 1);
    if (chg) begin @(negedge clk); ctrl_r = c_new; end
    got = '1; got[0] = 1'b0;
    for (int i = 1; i < n; i++) begin
      wait_tick_post();
      got[i] = txd;
    end
    wait_tick_post();
    chk(done == 1'b1, {tag, " R8 done pulse"}, 32'(done), 1);
    chk(txd == 1'b1 && stat == 2'b00, {tag, " R8 idle at done"}, {29'd0, txd, stat}, 32'h4);
    chk(got == f, {tag, " R4 R5 R6 frame bits"}, 32'(got), 32'(f));
    @(posedge clk); #1;
    chk(done == 1'b0, {tag, " R8 pulse one cycle"}, 32'(done), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL watchdog: run hung act=timeout exp=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin : main
    logic [7:0] pats [5];
    bit seen, all_hi;
    int k;
    pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C; pats[4] = 8'h81;

    #1;
    chk(txd == 1'b1 && stat == 2'b00 && done == 1'b0, "R1 reset state",
        {29'd0, txd, stat}, 32'h4);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(txd == 1'b1 && stat == 2'b00 && done == 1'b0, "R1 after reset release",
        {29'd0, txd, stat}, 32'h4);

    // R2: writes with either enable low have no effect
    ctrl_r = 8'h84;
    write_byte(8'h55);
    repeat (3) wait_tick_post();
    chk(stat == 2'b00 && txd == 1'b1, "R2 write ignored tx_en=0", 32'(stat), 0);
    ctrl_r = 8'h44;
    write_byte(8'h55);
    repeat (3) wait_tick_post();
    chk(stat == 2'b00 && txd == 1'b1, "R2 write ignored clk_en=0", 32'(stat), 0);

    // R9: guard holds the first frame until the third tick
    ctrl_r = 8'h00;
    repeat (2) @(negedge clk);
    wait_tick_post();
    @(negedge clk); ctrl_r = 8'hC4; wr = 1'b1; wdata = 8'h96;
    @(negedge clk); wr = 1'b0;
    k = 0; seen = 0;
    while (k < 10 && !seen) begin
      wait_tick_post(); k++;
      if (txd == 1'b0) seen = 1;
    end
    chk(seen && k == 3, "R9 first start tick index", 32'(k), 3);
    repeat (12) wait_tick_post();

    // R2 R4 R5 R6: full sweep of frame settings
    for (int ps = 0; ps < 4; ps++)
      for (int cl = 0; cl < 2; cl++)
        for (int sl = 0; sl < 2; sl++)
          for (int p = 0; p < 5; p++) begin
            logic [7:0] c;
            c = 8'hC0 | 8'(ps << 3) | 8'(cl << 2) | 8'(sl << 1) | 8'((ps & 1) << 5);
            ctrl_r = c;
            write_byte(pats[p]);
            capture(c, pats[p], 1'b0, 8'h00, $sformatf("sweep c=%02h d=%02h", c, pats[p]));
          end

    // R3: second write while full is dropped
    ctrl_r = 8'hC4;
    wait_tick_post();
    @(negedge clk); wr = 1'b1; wdata = 8'h5A;
    @(negedge clk); wdata = 8'hC3;
    @(negedge clk); wr = 1'b0;
    capture(8'hC4, 8'h5A, 1'b0, 8'h00, "R3 keep first");
    repeat (4) wait_tick_post();
    chk(stat == 2'b00 && txd == 1'b1, "R3 second byte discarded", 32'(stat), 0);

    // R7: queued byte shows both flags, then follows
    ctrl_r = 8'hDA;
    write_byte(8'h17);
    wait_start(seen);
    chk(stat == 2'b01, "R7 shifting only", 32'(stat), 1);
    write_byte(8'hE8);
    chk(stat == 2'b11, "R7 both flags", 32'(stat), 3);
    k = 0;
    do begin @(posedge clk); #1; k++; end while (!done && k < 400);
    capture(8'hDA, 8'hE8, 1'b0, 8'h00, "R7 queued byte");

    // R11: settings change mid-frame has no effect
    ctrl_r = 8'hC0;
    write_byte(8'h6D);
    capture(8'hC0, 8'h6D, 1'b1, 8'hDE, "R11 latched cfg");

    // R10: clock-enable drop mid-frame
    ctrl_r = 8'hC4;
    write_byte(8'h00);
    wait_start(seen);
    repeat (3) wait_tick_post();
    write_byte(8'h00);
    chk(stat == 2'b11, "R10 pre-drop flags", 32'(stat), 3);
    @(negedge clk); ctrl_r = 8'h44;
    #1;
    chk(txd == 1'b1 && stat == 2'b00, "R10 same-cycle idle", {30'd0, txd, stat[0]}, 32'h2);
    @(negedge clk); ctrl_r = 8'hC4;
    all_hi = 1;
    for (int i = 0; i < 20; i++) begin
      wait_tick_post();
      if (txd != 1'b1 || done) all_hi = 0;
    end
    chk(all_hi && stat == 2'b00, "R10 buffer discarded", {30'd0, all_hi, stat[1]}, 32'h2);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule